// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block is the software-visible register file of an I/O interrupt controller. A bus master sees only two 32-bit locations: a select register that holds a register index, and a data window through which the register named by that index is read or written. Behind the window sit an identifier register, a fixed version register, an arbitration register and a routing table with one 64-bit entry per interrupt pin. Each entry is reached as two 32-bit halves.

Interrupt delivery is done elsewhere. The block exports every table entry on a flat bus and raises a one-cycle strobe with the pin number whenever software writes an entry. The delivery logic owns two status bits of each entry, the in-flight (delivery status) bit and the remote-acknowledge-pending bit. It drives them through per-pin inputs, and software cannot write them.

Top module: `irq_route_regs`

## Requirements
- R1: An access is honoured only when `bus_size` is 2 (four bytes; 0 = one byte, 1 = two, 3 = eight) and `bus_addr` is 0x00 (select) or 0x10 (window). Any other write changes nothing and raises no strobe. Any other read returns 0.
- R2: The select register reads back the full 32-bit value last written to it. Only its bits 7:0 choose the register behind the window.
- R3: Window indices are decoded as follows. 0x00 is the identifier, 0x01 the version and 0x02 the arbitration register. Index 0x10+2p is the low half of pin p's entry and 0x11+2p is its high half. Every other index reads 0, and a write to it changes nothing.
- R4: The version register reads ((NPINS-1) << 16) | 0x11, which is 0x001F0011 for 32 pins. Writes to it have no effect.
- R5: The identifier register keeps only bits 27:24 of a written value and reads 0 elsewhere. The arbitration register reads the same value as the identifier and ignores writes.
- R6: After reset every entry holds 0x0001_0000_0001_0000, with bit 16 (mask) set. The select and identifier registers read 0.
- R7: Entry bits 12 (delivery status) and 14 (remote acknowledge pending) keep their values on a low-half write. Every other bit of the written half takes the written data.
- R8: After any write to either half of an entry, if the entry's bit 15 (trigger, 1 = level) is 0 and bit 14 is set, bit 14 reads 0. This clearing takes priority over a set arriving in the same cycle.
- R9: A pulse on `rirr_set[p]` sets bit 14 of entry p and a pulse on `rirr_clr[p]` clears it; when both are high, the clear wins. Bit 12 of entry p shows `dlv_busy[p]` as sampled on the previous clock edge.
- R10: A write takes effect at the clock edge that samples the request. A read returns its data with `bus_rvalid` high in the cycle after the request. After a table write, `ent_wr_stb` is high for exactly one cycle, with `ent_wr_pin` = p.
- R11: `tbl_flat[64p+63:64p]` always shows entry p. The fields are vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], mask [16] and destination [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OFF_W | Byte offset of the access |
| bus_size | input | 2 | log2 of access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| rirr_set | input | NPINS | Per-pin set of the remote-acknowledge bit |
| rirr_clr | input | NPINS | Per-pin clear of the remote-acknowledge bit |
| dlv_busy | input | NPINS | Per-pin delivery-in-progress status |
| tbl_flat | output | 64*NPINS | All routing entries, pin 0 in the low bits |
| ent_wr_stb | output | 1 | Pulse after a software write to a table entry |
| ent_wr_pin | output | PIN_W | Pin number that goes with ent_wr_stb |

## Verification
A wrong select value or a wrong decode shows up on the next window read, one cycle after the request, as data taken from the wrong register or as a zero in place of data. A corrupted entry, a lost protected bit or a missed remote-acknowledge clear shows on `tbl_flat` on the first clock edge after the write or status pulse that caused it, so the bench compares the whole table against its model after every step. A strobe that is missing, lasts too long or appears on a non-table write shows on `ent_wr_stb` in the cycle after the request.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Entry field positions that other logic decodes
    localparam int DLV_BIT  = 12;
    localparam int RIRR_BIT = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;

    // Hardware-owned bits of the low half
    localparam logic [31:0] RO_LO = (32'h1 << DLV_BIT) | (32'h1 << RIRR_BIT);

    // Reset image: both halves carry bit 16 of their word
    localparam logic [63:0] ENTRY_RST = 64'h0001_0000_0001_0000;

    // Access size code for a 32-bit access (log2 of bytes)
    localparam logic [1:0] SIZE_WORD = 2'd2;

    // Identifier field inside the written word
    localparam int ID_LSB = 24;
    localparam int ID_W   = 4;

    localparam logic [31:0] VER_TAG = 32'h0000_0011;

    typedef enum logic [2:0] {
        WK_NONE,
        WK_ID,
        WK_VER,
        WK_ARB,
        WK_TBL
    } win_kind_e;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int OFF_W     = 8,
    parameter logic [7:0] SEL_OFF  = 8'h00,
    parameter logic [7:0] WIN_OFF  = 8'h10,
    parameter logic [7:0] ID_IDX   = 8'h00,
    parameter logic [7:0] VER_IDX  = 8'h01,
    parameter logic [7:0] ARB_IDX  = 8'h02,
    parameter logic [7:0] TBL_BASE = 8'h10,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [OFF_W-1:0] bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [7:0]       sel_idx,
    output logic             acc_ok,
    output logic             is_sel,
    output win_kind_e        kind,
    output logic [PIN_W-1:0] pin,
    output logic             hi
);

    localparam logic [8:0] TBL_SPAN = 9'(2 * NPINS);

    logic [8:0] off9;
    logic       in_tbl;

    always_comb begin
        is_sel = (bus_addr == OFF_W'(SEL_OFF));
        acc_ok = (bus_size == SIZE_WORD) &&
                 (is_sel || (bus_addr == OFF_W'(WIN_OFF)));

        off9   = {1'b0, sel_idx} - {1'b0, TBL_BASE};
        in_tbl = (sel_idx >= TBL_BASE) && (off9 < TBL_SPAN);
        pin    = off9[PIN_W:1];
        hi     = off9[0];

        if (sel_idx == ID_IDX) begin
            kind = WK_ID;
        end else if (sel_idx == VER_IDX) begin
            kind = WK_VER;
        end else if (sel_idx == ARB_IDX) begin
            kind = WK_ARB;
        end else if (in_tbl) begin
            kind = WK_TBL;
        end else begin
            kind = WK_NONE;
        end
    end

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
    import irq_route_pkg::*;
#(
    parameter logic [63:0] RST_VAL = ENTRY_RST
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        dlv_busy,
    output logic [63:0] ent
);

    logic [63:0] ent_d;
    logic [63:0] ent_q;

    always_comb begin
        ent_d = ent_q;

        // Status bits owned by the delivery side
        ent_d[DLV_BIT] = dlv_busy;
        if (rirr_clr) begin
            ent_d[RIRR_BIT] = 1'b0;
        end else if (rirr_set) begin
            ent_d[RIRR_BIT] = 1'b1;
        end

        // Software halves; low half keeps the hardware-owned bits
        if (wr_lo) begin
            ent_d[31:0] = (wdata & ~RO_LO) | (ent_d[31:0] & RO_LO);
        end
        if (wr_hi) begin
            ent_d[63:32] = wdata;
        end

        // Edge-triggered entry cannot hold a pending acknowledge after a write
        if ((wr_lo || wr_hi) && !ent_d[TRIG_BIT] && ent_d[RIRR_BIT]) begin
            ent_d[RIRR_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q <= RST_VAL;
        end else begin
            ent_q <= ent_d;
        end
    end

    assign ent = ent_q;

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  win_kind_e          kind,
    input  logic [PIN_W-1:0]   pin,
    input  logic               hi,
    input  logic [ID_W-1:0]    id,
    input  logic [64*NPINS-1:0] tbl_flat,
    output logic [31:0]        rd_data
);

    localparam logic [31:0] VER_WORD = (32'(NPINS - 1) << 16) | VER_TAG;

    logic [63:0] sel_ent;
    logic [31:0] id_word;

    always_comb begin
        sel_ent = tbl_flat[int'(pin) * 64 +: 64];
        id_word = 32'(id) << ID_LSB;
        case (kind)
            WK_ID:   rd_data = id_word;
            WK_ARB:  rd_data = id_word;
            WK_VER:  rd_data = VER_WORD;
            WK_TBL:  rd_data = hi ? sel_ent[63:32] : sel_ent[31:0];
            default: rd_data = 32'h0;
        endcase
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int OFF_W = 8,
    parameter logic [7:0] SEL_OFF  = 8'h00,
    parameter logic [7:0] WIN_OFF  = 8'h10,
    parameter logic [7:0] ID_IDX   = 8'h00,
    parameter logic [7:0] VER_IDX  = 8'h01,
    parameter logic [7:0] ARB_IDX  = 8'h02,
    parameter logic [7:0] TBL_BASE = 8'h10,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [OFF_W-1:0]     bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NPINS-1:0]     rirr_set,
    input  logic [NPINS-1:0]     rirr_clr,
    input  logic [NPINS-1:0]     dlv_busy,
    output logic [64*NPINS-1:0]  tbl_flat,
    output logic                 ent_wr_stb,
    output logic [PIN_W-1:0]     ent_wr_pin
);

    typedef struct packed {
        logic [31:0]      sel;
        logic [ID_W-1:0]  id;
        logic [31:0]      rdata;
        logic             rvalid;
        logic             stb;
        logic [PIN_W-1:0] pin;
    } regs_t;

    regs_t s_d;
    regs_t s_q;

    logic             acc_ok;
    logic             is_sel;
    win_kind_e        kind;
    logic [PIN_W-1:0] tpin;
    logic             thi;
    logic [31:0]      win_rd;
    logic             win_wr;
    logic [NPINS-1:0] wr_lo;
    logic [NPINS-1:0] wr_hi;

    irq_route_decode #(
        .NPINS   (NPINS),
        .OFF_W   (OFF_W),
        .SEL_OFF (SEL_OFF),
        .WIN_OFF (WIN_OFF),
        .ID_IDX  (ID_IDX),
        .VER_IDX (VER_IDX),
        .ARB_IDX (ARB_IDX),
        .TBL_BASE(TBL_BASE)
    ) u_dec (
        .bus_addr(bus_addr),
        .bus_size(bus_size),
        .sel_idx (s_q.sel[7:0]),
        .acc_ok  (acc_ok),
        .is_sel  (is_sel),
        .kind    (kind),
        .pin     (tpin),
        .hi      (thi)
    );

    irq_route_rdmux #(
        .NPINS(NPINS)
    ) u_rdmux (
        .kind    (kind),
        .pin     (tpin),
        .hi      (thi),
        .id      (s_q.id),
        .tbl_flat(tbl_flat),
        .rd_data (win_rd)
    );

    assign win_wr = bus_req && bus_we && acc_ok && !is_sel && (kind == WK_TBL);

    for (genvar p = 0; p < NPINS; p++) begin : g_ent
        assign wr_lo[p] = win_wr && (tpin == PIN_W'(p)) && !thi;
        assign wr_hi[p] = win_wr && (tpin == PIN_W'(p)) &&  thi;

        irq_route_entry #(
            .RST_VAL(ENTRY_RST)
        ) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (wr_lo[p]),
            .wr_hi   (wr_hi[p]),
            .wdata   (bus_wdata),
            .rirr_set(rirr_set[p]),
            .rirr_clr(rirr_clr[p]),
            .dlv_busy(dlv_busy[p]),
            .ent     (tbl_flat[64*p +: 64])
        );
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        s_d.stb    = 1'b0;

        if (bus_req && !bus_we) begin
            s_d.rvalid = 1'b1;
            if (!acc_ok) begin
                s_d.rdata = 32'h0;
            end else if (is_sel) begin
                s_d.rdata = s_q.sel;
            end else begin
                s_d.rdata = win_rd;
            end
        end

        if (bus_req && bus_we && acc_ok) begin
            if (is_sel) begin
                s_d.sel = bus_wdata;
            end else begin
                case (kind)
                    WK_ID: s_d.id = bus_wdata[ID_LSB +: ID_W];
                    WK_TBL: begin
                        s_d.stb = 1'b1;
                        s_d.pin = tpin;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata  = s_q.rdata;
    assign bus_rvalid = s_q.rvalid;
    assign ent_wr_stb = s_q.stb;
    assign ent_wr_pin = s_q.pin;

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
    parameter int NPINS = 32,
    parameter int OFF_W = 8,
    parameter logic [7:0] SEL_OFF = 8'h00,
    parameter logic [7:0] WIN_OFF = 8'h10,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_we,
    input logic [OFF_W-1:0]    bus_addr,
    input logic [1:0]          bus_size,
    input logic [31:0]         bus_rdata,
    input logic                bus_rvalid,
    input logic [NPINS-1:0]    dlv_busy,
    input logic [64*NPINS-1:0] tbl_flat,
    input logic                ent_wr_stb,
    input logic [PIN_W-1:0]    ent_wr_pin
);

    logic        legal;
    logic        win_wr;
    logic [63:0] stb_ent;
    logic        started;

    assign legal   = (bus_size == 2'd2) &&
                     ((bus_addr == OFF_W'(SEL_OFF)) || (bus_addr == OFF_W'(WIN_OFF)));
    assign win_wr  = bus_req && bus_we && legal && (bus_addr == OFF_W'(WIN_OFF));
    assign stb_ent = tbl_flat[int'(ent_wr_pin) * 64 +: 64];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_rvquiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    assert_rdzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !legal) |=> (bus_rdata == 32'h0));

    assert_nostb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> !ent_wr_stb);

    assert_edgeclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_wr_stb |-> !(stb_ent[14] && !stb_ent[15]));

    for (genvar p = 0; p < NPINS; p++) begin : g_dlv
        assert_dlvmirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
            started |-> (tbl_flat[64*p + 12] == $past(dlv_busy[p])));
    end

endmodule

bind irq_route_regs irq_route_regs_chk #(
    .NPINS  (NPINS),
    .OFF_W  (OFF_W),
    .SEL_OFF(SEL_OFF),
    .WIN_OFF(WIN_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .dlv_busy  (dlv_busy),
    .tbl_flat  (tbl_flat),
    .ent_wr_stb(ent_wr_stb),
    .ent_wr_pin(ent_wr_pin)
);

// File: tb/test_irq_route_regs.sv
module test_irq_route_regs;

    localparam int NP = 32;
    localparam logic [31:0] RO = 32'h0000_5000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_req = 1'b0;
    logic            bus_we = 1'b0;
    logic [7:0]      bus_addr = 8'h0;
    logic [1:0]      bus_size = 2'd2;
    logic [31:0]     bus_wdata = 32'h0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [NP-1:0]   rirr_set = '0;
    logic [NP-1:0]   rirr_clr = '0;
    logic [NP-1:0]   dlv_busy = '0;
    logic [64*NP-1:0] tbl_flat;
    logic            ent_wr_stb;
    logic [4:0]      ent_wr_pin;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] exp_tbl [NP];

    always #10 clk = ~clk;

    irq_route_regs i_irq_route_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .rirr_set  (rirr_set),
        .rirr_clr  (rirr_clr),
        .dlv_busy  (dlv_busy),
        .tbl_flat  (tbl_flat),
        .ent_wr_stb(ent_wr_stb),
        .ent_wr_pin(ent_wr_pin)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // One access; returns outputs seen in the cycle after the request
    task automatic op(input logic we, input logic [7:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic rv, output logic stb, output logic [4:0] pin);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        rd = bus_rdata; rv = bus_rvalid; stb = ent_wr_stb; pin = ent_wr_pin;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] wd,
                      output logic stb, output logic [4:0] pin);
        logic [31:0] rd; logic rv;
        op(1'b1, a, 2'd2, wd, rd, rv, stb, pin);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        logic rv; logic stb; logic [4:0] pin;
        op(1'b0, a, 2'd2, 32'h0, d, rv, stb, pin);
    endtask

    task automatic win_rd(input logic [7:0] idx, output logic [31:0] d);
        logic s; logic [4:0] p;
        wr(8'h00, {24'h0, idx}, s, p);
        rd(8'h10, d);
    endtask

    task automatic win_wr(input logic [7:0] idx, input logic [31:0] d,
                          output logic stb, output logic [4:0] pin);
        logic s; logic [4:0] p;
        wr(8'h00, {24'h0, idx}, s, p);
        wr(8'h10, d, stb, pin);
    endtask

    task automatic chk_tbl(input string tag);
        int bad;
        bad = 0;
        for (int p = 0; p < NP; p++) begin
            if (tbl_flat[64*p +: 64] !== exp_tbl[p]) begin
                if (bad == 0)
                    $display("FAIL %s pin %0d actual=%h expected=%h",
                             tag, p, tbl_flat[64*p +: 64], exp_tbl[p]);
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
    endtask

    task automatic pulse_hw(input int p, input logic s, input logic c);
        @(negedge clk);
        rirr_set[p] = s; rirr_clr[p] = c;
        @(negedge clk);
        rirr_set[p] = 1'b0; rirr_clr[p] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d, d2, e;
        logic stb, rv;
        logic [4:0] pin;

        for (int p = 0; p < NP; p++) exp_tbl[p] = 64'h0001_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6 reset state
        @(negedge clk);
        chk_tbl("R6 reset table");
        rd(8'h00, d);
        chk("R6 select after reset", d, 0);
        rd(8'h10, d);
        chk("R6 id after reset", d, 0);

        // R4 version, write ignored
        win_rd(8'h01, d);
        chk("R4 version", d, 32'h001F_0011);
        win_wr(8'h01, 32'hFFFF_FFFF, stb, pin);
        chk("R10 no strobe on version write", stb, 0);
        rd(8'h10, d);
        chk("R4 version after write", d, 32'h001F_0011);

        // R5 identifier and arbitration
        win_wr(8'h00, 32'hFFFF_FFFF, stb, pin);
        rd(8'h10, d);
        chk("R5 id keeps 27:24", d, 32'h0F00_0000);
        win_rd(8'h02, d);
        chk("R5 arb mirrors id", d, 32'h0F00_0000);
        wr(8'h10, 32'h0000_0000, stb, pin);
        rd(8'h10, d);
        chk("R5 arb ignores write", d, 32'h0F00_0000);
        win_wr(8'h00, 32'hA5A5_A5A5, stb, pin);
        rd(8'h10, d);
        chk("R5 id new value", d, 32'h0500_0000);

        // R2 select full readback, low byte decode
        wr(8'h00, 32'h1234_5601, stb, pin);
        rd(8'h00, d);
        chk("R2 select readback", d, 32'h1234_5601);
        rd(8'h10, d);
        chk("R2 upper select bits ignored", d, 32'h001F_0011);

        // R3 unmatched indices read zero and ignore writes
        begin
            int bad_rd;
            int bad_st;
            bad_rd = 0; bad_st = 0;
            for (int i = 3; i < 256; i++) begin
                if (i >= 8'h10 && i < 8'h10 + 2*NP) continue;
                win_rd(8'(i), d);
                if (d !== 0) bad_rd++;
                wr(8'h10, 32'hFFFF_FFFF, stb, pin);
                if (stb !== 0) bad_st++;
            end
            chk("R3 unmatched indices read zero", bad_rd, 0);
            chk("R3 unmatched writes no strobe", bad_st, 0);
            chk_tbl("R3 unmatched writes leave table");
            win_rd(8'h00, d);
            chk("R3 unmatched writes leave id", d, 32'h0500_0000);
        end

        // R1 size and offset filtering
        wr(8'h00, 32'h0000_0020, stb, pin);
        for (int s = 0; s < 4; s++) begin
            if (s == 2) continue;
            op(1'b1, 8'h00, 2'(s), 32'hDEAD_BEEF, d, rv, stb, pin);
            op(1'b1, 8'h10, 2'(s), 32'hDEAD_BEEF, d, rv, stb, pin);
            chk("R1 bad-size window write no strobe", stb, 0);
            op(1'b0, 8'h00, 2'(s), 32'h0, d, rv, stb, pin);
            chk("R1 bad-size read returns zero", d, 0);
            chk("R10 bad-size read still valid", rv, 1);
        end
        begin
            int bad;
            bad = 0;
            for (int a = 0; a < 256; a++) begin
                if (a == 8'h00 || a == 8'h10) continue;
                op(1'b1, 8'(a), 2'd2, 32'h0000_0011, d, rv, stb, pin);
                op(1'b0, 8'(a), 2'd2, 32'h0, d, rv, stb, pin);
                if (d !== 0) bad++;
            end
            chk("R1 bad offsets read zero", bad, 0);
        end
        rd(8'h00, d);
        chk("R1 select untouched by filtered writes", d, 32'h0000_0020);
        chk_tbl("R1 table untouched by filtered writes");

        // R3 R11 R10 full table sweep
        for (int p = 0; p < NP; p++) begin
            for (int h = 0; h < 2; h++) begin
                d = 32'h9E37_79B9 * 32'(2*p + h + 1);
                win_wr(8'(8'h10 + 2*p + h), d, stb, pin);
                if (h == 0)
                    exp_tbl[p][31:0] = (d & ~RO) | (exp_tbl[p][31:0] & RO);
                else
                    exp_tbl[p][63:32] = d;
                if (stb !== 1'b1 || pin !== 5'(p)) begin
                    chk("R10 table write strobe and pin", {stb, 3'b0, pin}, {1'b1, 3'b0, 5'(p)});
                end
                @(negedge clk);
                if (ent_wr_stb !== 1'b0) chk("R10 strobe one cycle", ent_wr_stb, 0);
                rd(8'h10, d2);
                e = h ? exp_tbl[p][63:32] : exp_tbl[p][31:0];
                if (d2 !== e) chk("R3 table readback", d2, e);
            end
        end
        chk("R10 sweep strobe checks", 0, 0);
        chk_tbl("R11 table after sweep");

        // R7 protected bits kept on low-half write
        win_wr(8'h1A, 32'h0000_8022, stb, pin);
        exp_tbl[5][31:0] = 32'h0000_8022;
        @(negedge clk);
        dlv_busy[5] = 1'b1;
        pulse_hw(5, 1'b1, 1'b0);
        exp_tbl[5][31:0] = 32'h0000_D022;
        chk_tbl("R9 set status bits");
        win_wr(8'h1A, 32'h0000_8033, stb, pin);
        rd(8'h10, d);
        chk("R7 protected bits kept", d, 32'h0000_D033);
        exp_tbl[5][31:0] = 32'h0000_D033;
        win_wr(8'h1C, 32'h0000_D000, stb, pin);
        rd(8'h10, d);
        chk("R7 protected bits not writable", d, 32'h0000_8000);
        exp_tbl[6][31:0] = 32'h0000_8000;
        chk_tbl("R7 table");

        // R8 edge clear
        win_wr(8'h1B, 32'hAB00_0000, stb, pin);
        exp_tbl[5][63:32] = 32'hAB00_0000;
        chk_tbl("R8 level entry keeps pending bit");
        win_wr(8'h1A, 32'h0000_0044, stb, pin);
        rd(8'h10, d);
        chk("R8 edge write clears pending", d, 32'h0000_1044);
        exp_tbl[5][31:0] = 32'h0000_1044;
        pulse_hw(5, 1'b1, 1'b0);
        exp_tbl[5][31:0] = 32'h0000_5044;
        chk_tbl("R9 set on edge entry");
        win_wr(8'h1B, 32'hCD00_0000, stb, pin);
        exp_tbl[5] = {32'hCD00_0000, 32'h0000_1044};
        chk_tbl("R8 high-half write clears pending");

        // R9 clear, clear priority, delivery mirror
        pulse_hw(5, 1'b1, 1'b0);
        pulse_hw(5, 1'b0, 1'b1);
        chk_tbl("R9 clear pulse");
        pulse_hw(5, 1'b1, 1'b1);
        chk_tbl("R9 clear wins over set");
        @(negedge clk);
        dlv_busy[5] = 1'b0;
        @(negedge clk);
        exp_tbl[5][31:0] = 32'h0000_0044;
        chk_tbl("R9 delivery bit follows input");

        finish_run();
    end

endmodule